// File: doc/BRIEF.md
# Full-Duplex Serial Shift Controller (Master or Slave)

This block moves one word out and one word in at the same time over a four-wire synchronous serial link. It can be the side that drives the clock (master) or the side that follows an external clock and select line (slave). A configuration input picks the role. Each frame carries from 2 to 16 bits, and another configuration bit sets whether the most significant bit goes out first or last. The same order applies to the receive side.

The host places a word on `tx_data`. As master it pulses `start`. As slave it waits for the remote master to pull the select line low. `busy` is high while the frame is in progress. At the end `done` rises and `rx_data` holds the received word, right-justified. The serial clock idles low. Outgoing data changes after a falling clock edge, and incoming data is captured on a rising edge.

In master mode a half-period counter sets the clock rate. In slave mode the external clock, select and data lines pass through two flip-flops each, and clock edges are found by comparing consecutive synchronised samples in the module clock domain.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: `cfg_master`=1 selects master operation: `start` opens a frame and the slave pins are ignored. `cfg_master`=0 selects slave operation: the frame opens when the synchronised `s_cs_n` is low, and `start` is ignored.
- R2: Every frame shifts one bit out and one bit in per serial clock cycle. The outgoing word is taken from `tx_data` when the frame starts, and the incoming word appears on `rx_data` when the frame ends.
- R3: The 5-bit `cfg_len` field gives the frame length in bits. Values 2 to 16 are used as given, values 0 and 1 act as 2, and values 17 to 31 act as 16.
- R4: With `cfg_lsb_first`=0, bit L-1 of the word is shifted first and bit 0 last. With `cfg_lsb_first`=1, bit 0 is shifted first. The same order is used for receive.
- R5: The serial clock idles low. The output data bit changes only while the clock is low and is stable while it is high. The incoming bit is captured on the rising edge.
- R6: In master mode each clock phase lasts `cfg_div`+1 module clocks. A frame of L bits keeps `m_cs_n` low for exactly 2·L·(`cfg_div`+1) module clocks after the clock edge that accepts `start`.
- R7: `rx_data` is right-justified. Bits L-1..0 hold the received word, and bits above L-1 are zero.
- R8: `busy` is high from the cycle after a frame opens until it completes. `done` goes high when a frame completes, stays high while idle, and clears when the next frame opens. `done` and `busy` are never high together.
- R9: In slave mode the external clock may run at up to half the module clock for capture. For full-duplex operation, each phase of the external clock lasts at least four module clocks, so that `s_miso` settles after the synchronisation delay.
- R10: In slave mode, raising `s_cs_n` before the last bit is captured aborts the frame. `busy` drops, `done` stays low, `rx_data` keeps its previous value, and the bit counter restarts at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_len | input | 5 | Frame length in bits (clamped to 2..16) |
| cfg_div | input | DIV_W | Master clock half-period minus one, in module clocks |
| tx_data | input | 16 | Word to transmit |
| start | input | 1 | Master frame start strobe |
| rx_data | output | 16 | Last received word, right-justified |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame completed |
| m_sclk | output | 1 | Serial clock driven in master role |
| m_cs_n | output | 1 | Active-low select driven in master role |
| m_mosi | output | 1 | Serial data out in master role |
| m_miso | input | 1 | Serial data in for master role |
| s_sclk | input | 1 | External serial clock in slave role |
| s_cs_n | input | 1 | External active-low select in slave role |
| s_mosi | input | 1 | Serial data in for slave role |
| s_miso | output | 1 | Serial data out in slave role |

## Verification
A wrong bit counter or bit-index calculation shows up as a wrong `m_mosi` level within one clock phase of the error, because the bench predicts every master pin on every module clock from the elapsed cycle count. A divider that is off by one shifts the expected `m_sclk` toggle by a cycle and is caught at the first edge. Errors on the receive path show in `rx_data` when `done` rises. Slave-side faults such as a missed edge or a counter that survives an abort show as a wrong `s_miso` bit before the next rising edge, or as a wrong word at the end of the following frame.

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl #(
  parameter int DIV_W = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DW),
  localparam int LW   = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_lsb_first,
  input  logic [LW-1:0]    cfg_len,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [DW-1:0]    tx_data,
  input  logic             start,
  output logic [DW-1:0]    rx_data,
  output logic             busy,
  output logic             done,
  output logic             m_sclk,
  output logic             m_cs_n,
  output logic             m_mosi,
  input  logic             m_miso,
  input  logic             s_sclk,
  input  logic             s_cs_n,
  input  logic             s_mosi,
  output logic             s_miso
);

  typedef enum logic [1:0] {ST_IDLE, ST_MRUN, ST_SRUN, ST_SHOLD} st_t;

  st_t             st;
  logic [DW-1:0]   tx_q, rx_sh;
  logic [CW-1:0]   cnt, last_q, last_cfg, bit_idx;
  logic            lsb_q, sck_q;
  logic [DIV_W-1:0] tmr, div_q;
  logic [2:0]      ssck, scs;
  logic [1:0]      smosi;
  logic            s_rise, s_fall, cs_act, out_bit;

  always_comb begin
    if (cfg_len < LW'(2))       last_cfg = CW'(1);
    else if (cfg_len > LW'(DW)) last_cfg = CW'(DW - 1);
    else                        last_cfg = CW'(cfg_len - LW'(1));
  end

  assign bit_idx = lsb_q ? cnt : last_q - cnt;
  assign out_bit = tx_q[bit_idx];
  assign s_rise  = ssck[1] & ~ssck[2];
  assign s_fall  = ~ssck[1] & ssck[2];
  assign cs_act  = ~scs[1];

  assign busy   = (st == ST_MRUN) || (st == ST_SRUN);
  assign m_sclk = (st == ST_MRUN) && sck_q;
  assign m_cs_n = (st != ST_MRUN);
  assign m_mosi = (st == ST_MRUN) && out_bit;
  assign s_miso = ((st == ST_SRUN) || (st == ST_SHOLD)) && out_bit;

  function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] r, input logic b,
                                            input logic lsb, input logic [CW-1:0] pos);
    if (lsb) put_bit = r | (DW'(b) << pos);
    else     put_bit = {r[DW-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssck  <= '0;
      scs   <= '1;
      smosi <= '0;
    end else begin
      ssck  <= {ssck[1:0], s_sclk};
      scs   <= {scs[1:0], s_cs_n};
      smosi <= {smosi[0], s_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tx_q    <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      cnt     <= '0;
      last_q  <= CW'(1);
      lsb_q   <= 1'b0;
      sck_q   <= 1'b0;
      tmr     <= '0;
      div_q   <= '0;
      done    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if ((cfg_master && start) || (!cfg_master && cs_act)) begin
            st     <= cfg_master ? ST_MRUN : ST_SRUN;
            tx_q   <= tx_data;
            rx_sh  <= '0;
            cnt    <= '0;
            last_q <= last_cfg;
            lsb_q  <= cfg_lsb_first;
            div_q  <= cfg_div;
            tmr    <= '0;
            sck_q  <= 1'b0;
            done   <= 1'b0;
          end
        end
        ST_MRUN: begin
          if (tmr == div_q) begin
            tmr <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sh <= put_bit(rx_sh, m_miso, lsb_q, cnt);
            end else begin
              sck_q <= 1'b0;
              if (cnt == last_q) begin
                st      <= ST_IDLE;
                done    <= 1'b1;
                rx_data <= rx_sh;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
          end else begin
            tmr <= tmr + DIV_W'(1);
          end
        end
        ST_SRUN: begin
          if (!cs_act) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else if (s_rise) begin
            rx_sh <= put_bit(rx_sh, smosi[1], lsb_q, cnt);
            if (cnt == last_q) begin
              st      <= ST_SHOLD;
              done    <= 1'b1;
              rx_data <= put_bit(rx_sh, smosi[1], lsb_q, cnt);
            end
          end else if (s_fall) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_SHOLD: begin
          if (!cs_act) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_mosi_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sclk && $past(m_sclk)) |-> $stable(m_mosi));

  p_rx_justified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((32'(rx_data) >> (32'(last_q) + 32'd1)) == 32'd0));

  p_cnt_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= last_q));

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SRUN && !cs_act) |=> (!done && !busy));

  p_slave_role_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SRUN) |-> (m_cs_n && !m_sclk && !m_mosi));

endmodule

// File: tb/spi_duplex_ctrl_tb.sv
module spi_duplex_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_lsb_first = 0, start = 0;
  logic [4:0] cfg_len = 5'd8;
  logic [7:0] cfg_div = 8'd0;
  logic [15:0] tx_data = '0, rx_data;
  logic busy, done, m_sclk, m_cs_n, m_mosi, m_miso = 0;
  logic s_sclk = 0, s_cs_n = 1, s_mosi = 0, s_miso;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  spi_duplex_ctrl dut_i (.clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_div(cfg_div),
    .tx_data(tx_data), .start(start), .rx_data(rx_data), .busy(busy), .done(done),
    .m_sclk(m_sclk), .m_cs_n(m_cs_n), .m_mosi(m_mosi), .m_miso(m_miso),
    .s_sclk(s_sclk), .s_cs_n(s_cs_n), .s_mosi(s_mosi), .s_miso(s_miso));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int eff_len(input logic [4:0] f);
    return (f < 2) ? 2 : ((f > 16) ? 16 : int'(f));
  endfunction

  task automatic run_master(input logic [15:0] txw, input logic [15:0] slw,
                            input logic [4:0] lf, input logic lsb, input int dv);
    int L = eff_len(lf);
    int half = dv + 1;
    logic [15:0] mask = 16'((32'd1 << L) - 1);
    @(negedge clk);
    cfg_master = 1; cfg_len = lf; cfg_lsb_first = lsb; cfg_div = 8'(dv);
    tx_data = txw; start = 1;
    m_miso = slw[lsb ? 0 : L-1];
    @(negedge clk);
    start = 0;
    tx_data = ~txw;
    for (int n = 0; n <= 2*L*half; n++) begin
      int k = n / half;
      if (k < 2*L) begin
        int idx = lsb ? k/2 : L-1-k/2;
        chk("R6 m_sclk phase", m_sclk, k % 2);
        chk("R6 m_cs_n low", m_cs_n, 0);
        chk("R8 busy in frame", busy, 1);
        chk("R8 done cleared", done, 0);
        chk("R4 m_mosi bit", m_mosi, txw[idx]);
        m_miso = slw[idx];
      end else begin
        chk("R6 m_cs_n high at end", m_cs_n, 1);
        chk("R5 m_sclk idle low", m_sclk, 0);
        chk("R8 busy end", busy, 0);
        chk("R8 done end", done, 1);
        chk("R2 R7 rx_data master", rx_data, slw & mask);
      end
      if (n < 2*L*half) @(negedge clk);
    end
  endtask

  task automatic run_slave(input logic [15:0] txw, input logic [15:0] mw,
                           input logic [4:0] lf, input logic lsb, input int P,
                           input int abort_after);
    int L = eff_len(lf);
    logic [15:0] mask = 16'((32'd1 << L) - 1);
    logic [15:0] prev_rx = rx_data;
    @(negedge clk);
    cfg_master = 0; cfg_len = lf; cfg_lsb_first = lsb; tx_data = txw;
    s_mosi = mw[lsb ? 0 : L-1];
    s_cs_n = 0;
    repeat (4) @(negedge clk);
    tx_data = ~txw;
    chk("R8 slave busy open", busy, 1);
    chk("R8 slave done cleared", done, 0);
    for (int j = 0; j < L; j++) begin
      if (j == abort_after) begin
        s_cs_n = 1;
        repeat (5) @(negedge clk);
        chk("R10 abort busy", busy, 0);
        chk("R10 abort done", done, 0);
        chk("R10 abort rx kept", rx_data, prev_rx);
        chk("R10 abort miso", s_miso, 0);
        return;
      end
      chk("R9 R4 s_miso bit", s_miso, txw[lsb ? j : L-1-j]);
      s_sclk = 1;
      repeat (P) @(negedge clk);
      s_sclk = 0;
      if (j + 1 < L) s_mosi = mw[lsb ? j+1 : L-2-j];
      repeat (P) @(negedge clk);
    end
    chk("R8 slave done", done, 1);
    chk("R8 slave busy end", busy, 0);
    chk("R2 R7 rx_data slave", rx_data, mw & mask);
    s_cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R5 reset m_sclk", m_sclk, 0);
    chk("R6 reset m_cs_n", m_cs_n, 1);
    chk("R7 reset rx_data", rx_data, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_master(16'hA5C3, 16'h3C96, 5'd16, 1'b0, 0);
    run_master(16'h00B4, 16'h005A, 5'd8, 1'b1, 2);
    run_master(16'h0002, 16'h0001, 5'd0, 1'b0, 1);
    run_master(16'h0001, 16'h0002, 5'd1, 1'b1, 0);
    run_master(16'h8421, 16'hF00D, 5'd31, 1'b1, 1);
    run_master(16'h0013, 16'hFFEA, 5'd5, 1'b0, 3);

    // R1: start ignored in slave role
    @(negedge clk); cfg_master = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    chk("R1 start ignored busy", busy, 0);
    chk("R1 start ignored cs", m_cs_n, 1);
    chk("R1 start ignored done", done, 1);
    // R1: slave select ignored in master role
    cfg_master = 1; s_cs_n = 0;
    repeat (6) @(negedge clk);
    chk("R1 s_cs_n ignored busy", busy, 0);
    chk("R1 s_cs_n ignored miso", s_miso, 0);
    s_cs_n = 1;
    repeat (4) @(negedge clk);

    run_slave(16'h0ABC, 16'h0963, 5'd12, 1'b0, 4, -1);
    run_slave(16'h0005, 16'h0006, 5'd3, 1'b1, 5, -1);
    run_slave(16'h1234, 16'h5678, 5'd16, 1'b0, 4, 5);
    run_slave(16'h00C7, 16'h0039, 5'd8, 1'b1, 4, -1);
    run_slave(16'h0001, 16'h0003, 5'd0, 1'b0, 4, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule